// File: doc/BRIEF.md
# Conditional-Zero Integer Execution Unit

This unit executes the two integer conditional-zero operations of a RISC-V core. An instruction word, a destination tag and two source operands arrive at the unit. The first source is the value operand and the second is the condition operand. Each operand has its own ready flag, so either one can arrive in the issue cycle or in a later cycle. The eqz form returns zero when the condition operand is zero and returns the value operand otherwise. The nez form returns zero when the condition operand is non-zero and returns the value operand otherwise. The result leaves the unit with its tag on a valid pulse. The instruction hands off to the next one and does not redirect control flow.

In the normal mode the condition operand alone can decide the outcome. When it selects zero, the unit completes without waiting for the value operand. The constant-time mode is sampled when an instruction is accepted. In that mode the unit always waits for both operands and completes a fixed two cycles after the later one, so the completion timing reveals nothing about either value. The unit holds one instruction at a time, and a synchronous flush drops it.

Top module: `czero_unit`

## Requirements
- R1: With funct3 101 (eqz), the result is all zeros if the condition operand is zero, and the value operand otherwise.
- R2: With funct3 111 (nez), the result is all zeros if the condition operand is non-zero, and the value operand otherwise.
- R3: In normal mode, a zero-selecting result is valid exactly one cycle after the cycle in which the condition operand is ready, whether or not the value operand has arrived.
- R4: In normal mode, a pass-through result is valid exactly one cycle after the cycle by which both operands have been ready.
- R5: In constant-time mode (sampled at acceptance), the result is valid exactly two cycles after the cycle by which both operands have been ready, for every combination of operand values.
- R6: While an instruction is held (busy high), a new issue is ignored: it gives no result and does not replace the held tag or operation.
- R7: A synchronous flush drops the held or issuing instruction. Busy is low in the next cycle, and no result valid is raised for that instruction.
- R8: An issue is accepted only if bits [6:0] are 0110011, bits [31:25] are 0000111 and funct3 (bits [14:12]) is 101 or 111. Any other word is ignored and raises no result.
- R9: The zero test on the condition operand covers all XLEN bits. A condition with only bit XLEN-1 set counts as non-zero.
- R10: Chained through the unit, nez(rs2, rc) followed by XOR with rs1 gives rs1 when rc is non-zero and rs1^rs2 otherwise. nez(rs1, rc) and eqz(rs2, rc) combined by OR give rs2 when rc is non-zero and rs1 otherwise.
- R11: During and directly after reset, busy and the result valid are low.
- R12: The result carries the destination tag given at issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ct_mode_i | input | 1 | Constant-time mode, sampled at acceptance |
| flush_i | input | 1 | Synchronous flush of the held instruction |
| issue_vld_i | input | 1 | Issue request |
| issue_inst_i | input | 32 | Instruction word |
| issue_tag_i | input | TAG_W | Destination tag |
| val_rdy_i | input | 1 | Value operand present this cycle |
| val_data_i | input | XLEN | Value operand |
| cond_rdy_i | input | 1 | Condition operand present this cycle |
| cond_data_i | input | XLEN | Condition operand |
| busy_o | output | 1 | An instruction is held |
| res_vld_o | output | 1 | Result valid pulse |
| res_tag_o | output | TAG_W | Result destination tag |
| res_data_o | output | XLEN | Result value |

## Verification
Cycles are numbered from the issue cycle, which is cycle 0. The result is due in cycle b+1 for a normal zero-select, in cycle max(a,b)+1 for a normal pass-through and in cycle max(a,b)+2 in constant-time mode, where a and b are the cycles in which the value and condition operands are ready. The bench drives every input at the falling edge and samples one time unit after each rising edge. It records the first cycle in which the valid is seen and compares that cycle to the one due. For dropped instructions (busy issue, flush, illegal word), it watches several cycles past the latest due cycle and confirms that no valid appears.

// File: rtl/czu_pkg.sv
package czu_pkg;
   localparam int INST_W = 32;
   localparam logic [6:0] OPC_OP   = 7'b0110011;
   localparam logic [6:0] F7_CZERO = 7'b0000111;
   localparam logic [2:0] F3_EQZ   = 3'b101;
   localparam logic [2:0] F3_NEZ   = 3'b111;

   typedef enum logic {
      CZ_EQZ = 1'b0,
      CZ_NEZ = 1'b1
   } cz_op_e;
endpackage

// File: rtl/czu_decode.sv
module czu_decode
   import czu_pkg::*;
(
   input  logic [INST_W-1:0] inst_i,
   output logic              legal_o,
   output cz_op_e            op_o
);
   logic [6:0] opc;
   logic [6:0] f7;
   logic [2:0] f3;

   always_comb begin
      opc     = inst_i[6:0];
      f7      = inst_i[31:25];
      f3      = inst_i[14:12];
      legal_o = (opc == OPC_OP) && (f7 == F7_CZERO) &&
                ((f3 == F3_EQZ) || (f3 == F3_NEZ));
      op_o    = (f3 == F3_NEZ) ? CZ_NEZ : CZ_EQZ;
   end
endmodule

// File: rtl/czu_slot.sv
module czu_slot #(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         cap_en_i,
   input  logic         rdy_i,
   input  logic [W-1:0] data_i,
   output logic         avail_o,
   output logic [W-1:0] data_o
);
   logic         held_q;
   logic [W-1:0] data_q;

   always_comb begin
      avail_o = held_q | (cap_en_i & rdy_i);
      data_o  = held_q ? data_q : data_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         data_q <= '0;
      end else if (clr_i) begin
         held_q <= 1'b0;
      end else if (cap_en_i && rdy_i && !held_q) begin
         held_q <= 1'b1;
         data_q <= data_i;
      end
   end
endmodule

// File: rtl/czu_select.sv
module czu_select
   import czu_pkg::*;
#(
   parameter int W          = 64,
   parameter bit BRANCHLESS = 1'b1
) (
   input  cz_op_e       op_i,
   input  logic [W-1:0] cond_i,
   input  logic [W-1:0] val_i,
   output logic         zsel_o,
   output logic [W-1:0] res_o
);
   logic cond_is_zero;

   always_comb begin
      cond_is_zero = ~|cond_i;
      zsel_o       = (op_i == CZ_NEZ) ? ~cond_is_zero : cond_is_zero;
   end

   generate
      if (BRANCHLESS) begin : g_mask
         assign res_o = val_i & {W{~zsel_o}};
      end else begin : g_mux
         assign res_o = zsel_o ? '0 : val_i;
      end
   endgenerate
endmodule

// File: rtl/czero_unit.sv
module czero_unit
   import czu_pkg::*;
#(
   parameter int XLEN       = 64,
   parameter int TAG_W      = 5,
   parameter bit BRANCHLESS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ct_mode_i,
   input  logic              flush_i,
   input  logic              issue_vld_i,
   input  logic [31:0]       issue_inst_i,
   input  logic [TAG_W-1:0]  issue_tag_i,
   input  logic              val_rdy_i,
   input  logic [XLEN-1:0]   val_data_i,
   input  logic              cond_rdy_i,
   input  logic [XLEN-1:0]   cond_data_i,
   output logic              busy_o,
   output logic              res_vld_o,
   output logic [TAG_W-1:0]  res_tag_o,
   output logic [XLEN-1:0]   res_data_o
);
   localparam int N_SLOT   = 2;
   localparam int SLOT_VAL = 0;
   localparam int SLOT_CND = 1;

   generate
      if (XLEN < 2) begin : g_bad_xlen
         $error("czero_unit: XLEN must be at least 2");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("czero_unit: TAG_W must be at least 1");
      end
   endgenerate

   logic              busy_q, ct_q, ct_arm_q;
   cz_op_e            op_q;
   logic [TAG_W-1:0]  tag_q;
   logic              res_vld_q;
   logic [TAG_W-1:0]  res_tag_q;
   logic [XLEN-1:0]   res_data_q;

   logic              dec_legal;
   cz_op_e            dec_op;
   logic              accept, live, ct_now, ct_both;
   logic              fire_norm, fire_ct, done;
   cz_op_e            op_now;
   logic [TAG_W-1:0]  tag_now;
   logic              zsel;
   logic [XLEN-1:0]   sel_res;

   logic [N_SLOT-1:0]            slot_rdy, slot_avail;
   logic [N_SLOT-1:0][XLEN-1:0]  slot_din, slot_dout;

   czu_decode u_dec (
      .inst_i  (issue_inst_i),
      .legal_o (dec_legal),
      .op_o    (dec_op)
   );

   always_comb begin
      accept  = issue_vld_i & ~busy_q & dec_legal & ~flush_i;
      live    = busy_q | accept;
      op_now  = busy_q ? op_q  : dec_op;
      ct_now  = busy_q ? ct_q  : ct_mode_i;
      tag_now = busy_q ? tag_q : issue_tag_i;
      slot_rdy[SLOT_VAL] = val_rdy_i;
      slot_rdy[SLOT_CND] = cond_rdy_i;
      slot_din[SLOT_VAL] = val_data_i;
      slot_din[SLOT_CND] = cond_data_i;
   end

   generate
      for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
         czu_slot #(.W(XLEN)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_i    (flush_i | done),
            .cap_en_i (live),
            .rdy_i    (slot_rdy[s]),
            .data_i   (slot_din[s]),
            .avail_o  (slot_avail[s]),
            .data_o   (slot_dout[s])
         );
      end
   endgenerate

   czu_select #(.W(XLEN), .BRANCHLESS(BRANCHLESS)) u_sel (
      .op_i   (op_now),
      .cond_i (slot_dout[SLOT_CND]),
      .val_i  (slot_dout[SLOT_VAL]),
      .zsel_o (zsel),
      .res_o  (sel_res)
   );

   always_comb begin
      fire_norm = live & ~ct_now & ~flush_i & slot_avail[SLOT_CND] &
                  (zsel | slot_avail[SLOT_VAL]);
      ct_both   = live & ct_now & slot_avail[SLOT_CND] & slot_avail[SLOT_VAL];
      fire_ct   = ct_arm_q & ~flush_i;
      done      = fire_norm | fire_ct;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         ct_q       <= 1'b0;
         ct_arm_q   <= 1'b0;
         op_q       <= CZ_EQZ;
         tag_q      <= '0;
         res_vld_q  <= 1'b0;
         res_tag_q  <= '0;
         res_data_q <= '0;
      end else begin
         res_vld_q <= done;
         if (done) begin
            res_tag_q  <= tag_now;
            res_data_q <= sel_res;
         end
         if (flush_i || done) begin
            busy_q <= 1'b0;
         end else if (accept) begin
            busy_q <= 1'b1;
         end
         if (accept) begin
            ct_q  <= ct_mode_i;
            op_q  <= dec_op;
            tag_q <= issue_tag_i;
         end
         ct_arm_q <= ct_both & ~ct_arm_q & ~flush_i;
      end
   end

   assign busy_o     = busy_q;
   assign res_vld_o  = res_vld_q;
   assign res_tag_o  = res_tag_q;
   assign res_data_o = res_data_q;
endmodule

// File: rtl/czero_unit_chk.sv
module czero_unit_chk #(
   parameter int XLEN  = 64,
   parameter int TAG_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ct_mode_i,
   input logic              flush_i,
   input logic              issue_vld_i,
   input logic [31:0]       issue_inst_i,
   input logic [TAG_W-1:0]  issue_tag_i,
   input logic              val_rdy_i,
   input logic [XLEN-1:0]   val_data_i,
   input logic              cond_rdy_i,
   input logic [XLEN-1:0]   cond_data_i,
   input logic              busy_o,
   input logic              res_vld_o,
   input logic [TAG_W-1:0]  res_tag_o,
   input logic [XLEN-1:0]   res_data_o
);
   logic word_ok, is_nez, takes, picks_zero;

   always_comb begin
      word_ok    = issue_inst_i[6:0] == 7'h33 && issue_inst_i[31:25] == 7'h07 &&
                   (issue_inst_i[14:12] == 3'd5 || issue_inst_i[14:12] == 3'd7);
      is_nez     = issue_inst_i[13];
      takes      = rst_n && issue_vld_i && !busy_o && word_ok && !flush_i;
      picks_zero = is_nez ? (cond_data_i != '0) : (cond_data_i == '0);
   end

   AST_FLUSH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> !busy_o); // R7
   AST_FLUSH_NO_RES: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> !res_vld_o); // R7
   AST_ILLEGAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && issue_vld_i && !word_ok) |=> (!res_vld_o && !busy_o)); // R8
   AST_EARLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (takes && !ct_mode_i && cond_rdy_i && picks_zero) |=> (res_vld_o && res_data_o == '0)); // R3
   AST_PASS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (takes && !ct_mode_i && cond_rdy_i && val_rdy_i && !picks_zero)
         |=> (res_vld_o && res_data_o == $past(val_data_i))); // R4
   AST_CT_NOT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
      (takes && ct_mode_i) |=> !res_vld_o); // R5
   AST_CT_TWO: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(takes && ct_mode_i && cond_rdy_i && val_rdy_i, 2) && !$past(flush_i))
         |-> res_vld_o); // R5
   AST_TAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (takes && !ct_mode_i && cond_rdy_i && picks_zero)
         |=> (res_tag_o == $past(issue_tag_i))); // R12
endmodule

bind czero_unit czero_unit_chk #(.XLEN(XLEN), .TAG_W(TAG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ct_mode_i(ct_mode_i), .flush_i(flush_i),
   .issue_vld_i(issue_vld_i), .issue_inst_i(issue_inst_i), .issue_tag_i(issue_tag_i),
   .val_rdy_i(val_rdy_i), .val_data_i(val_data_i), .cond_rdy_i(cond_rdy_i),
   .cond_data_i(cond_data_i), .busy_o(busy_o), .res_vld_o(res_vld_o),
   .res_tag_o(res_tag_o), .res_data_o(res_data_o)
);

// File: tb/czero_unit_test.sv
module czero_unit_test;
   localparam int XLEN  = 64;
   localparam int TAG_W = 5;

   typedef struct packed {
      logic            nez;
      logic            ct;
      logic [XLEN-1:0] a;
      logic [XLEN-1:0] b;
      logic [3:0]      ad;
      logic [3:0]      bd;
      logic [XLEN-1:0] exp;
   } vec_t;

   localparam int NVEC = 10;
   localparam logic [XLEN-1:0] MSB = {1'b1, {(XLEN-1){1'b0}}};
   localparam vec_t VEC [NVEC] = '{
      '{1'b0, 1'b0, 64'hDEAD, 64'h0,    4'd3, 4'd0, 64'h0},
      '{1'b0, 1'b0, 64'h1234, 64'h5,    4'd2, 4'd1, 64'h1234},
      '{1'b1, 1'b0, 64'hAAAA, 64'h7,    4'd4, 4'd0, 64'h0},
      '{1'b1, 1'b0, 64'h5555, 64'h0,    4'd0, 4'd2, 64'h5555},
      '{1'b0, 1'b0, 64'h77,   MSB,      4'd0, 4'd0, 64'h77},
      '{1'b1, 1'b0, 64'h77,   MSB,      4'd5, 4'd0, 64'h0},
      '{1'b0, 1'b1, 64'h99,   64'h0,    4'd3, 4'd0, 64'h0},
      '{1'b0, 1'b1, 64'h99,   64'h1,    4'd3, 4'd0, 64'h99},
      '{1'b1, 1'b1, {XLEN{1'b1}}, 64'h0, 4'd0, 4'd0, {XLEN{1'b1}}},
      '{1'b1, 1'b1, 64'h42,   64'h3,    4'd1, 4'd4, 64'h0}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ct_mode_i = 1'b0;
   logic              flush_i = 1'b0;
   logic              issue_vld_i = 1'b0;
   logic [31:0]       issue_inst_i = '0;
   logic [TAG_W-1:0]  issue_tag_i = '0;
   logic              val_rdy_i = 1'b0;
   logic [XLEN-1:0]   val_data_i = '0;
   logic              cond_rdy_i = 1'b0;
   logic [XLEN-1:0]   cond_data_i = '0;
   logic              busy_o, res_vld_o;
   logic [TAG_W-1:0]  res_tag_o;
   logic [XLEN-1:0]   res_data_o;

   int total = 0;
   int bad   = 0;
   bit ended = 1'b0;

   always #5 clk = ~clk;

   czero_unit #(.XLEN(XLEN), .TAG_W(TAG_W)) uut (.*);

   function automatic logic [31:0] mk_inst(input logic [2:0] f3, input logic [6:0] f7);
      return {f7, 5'd2, 5'd1, f3, 5'd3, 7'b0110011};
   endfunction

   task automatic check(input string req, input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic clear_inputs();
      issue_vld_i = 1'b0; val_rdy_i = 1'b0; cond_rdy_i = 1'b0; flush_i = 1'b0;
   endtask

   task automatic run_op(input logic nez, input logic ct, input logic [XLEN-1:0] a,
                         input logic [XLEN-1:0] b, input int ad, input int bd,
                         input logic [TAG_W-1:0] tag, output logic got,
                         output logic [XLEN-1:0] res, output logic [TAG_W-1:0] rtag,
                         output int cyc);
      got = 1'b0; res = '0; rtag = '0; cyc = -1;
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         issue_vld_i  = (k == 0);
         issue_inst_i = mk_inst(nez ? 3'b111 : 3'b101, 7'b0000111);
         issue_tag_i  = tag;
         ct_mode_i    = ct;
         val_rdy_i    = (k == ad);
         val_data_i   = (k == ad) ? a : '1;
         cond_rdy_i   = (k == bd);
         cond_data_i  = (k == bd) ? b : '1;
         @(posedge clk);
         #1;
         if (res_vld_o) begin
            got = 1'b1; res = res_data_o; rtag = res_tag_o; cyc = k + 1;
            break;
         end
      end
      @(negedge clk);
      clear_inputs();
   endtask

   task automatic watch_quiet(input int n, output int vlds);
      vlds = 0;
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         #1;
         if (res_vld_o) vlds++;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!ended) begin
         bad++; total++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic got;
      logic [XLEN-1:0] res, r1, r2;
      logic [TAG_W-1:0] rtag;
      int cyc, vlds, late, exp_cyc;
      logic zs;

      repeat (3) @(posedge clk);
      #1;
      check("R11 valid in reset", res_vld_o, 0);
      check("R11 busy in reset", busy_o, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check("R11 valid after reset", res_vld_o, 0);
      check("R11 busy after reset", busy_o, 0);

      // R1 R2 R3 R4 R5 R9 R12: vector table
      for (int i = 0; i < NVEC; i++) begin
         run_op(VEC[i].nez, VEC[i].ct, VEC[i].a, VEC[i].b, int'(VEC[i].ad), int'(VEC[i].bd),
                TAG_W'(i + 1), got, res, rtag, cyc);
         zs   = VEC[i].nez ? (VEC[i].b != '0) : (VEC[i].b == '0);
         late = (VEC[i].ad > VEC[i].bd) ? int'(VEC[i].ad) : int'(VEC[i].bd);
         if (VEC[i].ct)  exp_cyc = late + 2;
         else if (zs)    exp_cyc = int'(VEC[i].bd) + 1;
         else            exp_cyc = late + 1;
         check(VEC[i].nez ? "R2 R9 nez result" : "R1 R9 eqz result", res, VEC[i].exp);
         check(VEC[i].ct ? "R5 constant-time cycle" : (zs ? "R3 early zero cycle" : "R4 pass cycle"),
               XLEN'(cyc), XLEN'(exp_cyc));
         check("R12 tag", XLEN'(rtag), XLEN'(i + 1));
      end

      // R6: second issue while busy is ignored
      @(negedge clk);
      ct_mode_i = 1'b0;
      issue_vld_i = 1'b1; issue_inst_i = mk_inst(3'b101, 7'b0000111); issue_tag_i = 5'd3;
      @(negedge clk);
      issue_inst_i = mk_inst(3'b111, 7'b0000111); issue_tag_i = 5'd9;
      cond_rdy_i = 1'b1; cond_data_i = '0;
      @(posedge clk); #1;
      check("R6 held result valid", res_vld_o, 1);
      check("R6 held tag kept", XLEN'(res_tag_o), 64'd3);
      check("R6 held op kept (eqz on zero)", res_data_o, 0);
      @(negedge clk); clear_inputs();
      watch_quiet(6, vlds);
      check("R6 no result for ignored issue", XLEN'(vlds), 0);

      // R7: flush drops the held instruction
      @(negedge clk);
      issue_vld_i = 1'b1; issue_inst_i = mk_inst(3'b101, 7'b0000111); issue_tag_i = 5'd4;
      @(negedge clk);
      issue_vld_i = 1'b0; flush_i = 1'b1;
      @(posedge clk); #1;
      check("R7 busy low after flush", busy_o, 0);
      @(negedge clk);
      flush_i = 1'b0; cond_rdy_i = 1'b1; cond_data_i = '0; val_rdy_i = 1'b1;
      @(negedge clk); clear_inputs();
      watch_quiet(5, vlds);
      check("R7 no result after flush", XLEN'(vlds), 0);
      run_op(1'b0, 1'b0, 64'h31, 64'h2, 0, 0, 5'd6, got, res, rtag, cyc);
      check("R7 unit usable after flush", res, 64'h31);

      // R7: flush in the wait cycle of constant-time mode
      @(negedge clk);
      ct_mode_i = 1'b1; issue_vld_i = 1'b1; issue_inst_i = mk_inst(3'b111, 7'b0000111);
      val_rdy_i = 1'b1; cond_rdy_i = 1'b1; cond_data_i = '0; val_data_i = 64'h5;
      @(negedge clk); clear_inputs(); flush_i = 1'b1;
      @(negedge clk); flush_i = 1'b0;
      watch_quiet(4, vlds);
      check("R7 constant-time flush drops result", XLEN'(vlds), 0);

      // R8: illegal encodings ignored
      @(negedge clk);
      ct_mode_i = 1'b0; issue_vld_i = 1'b1; issue_inst_i = mk_inst(3'b110, 7'b0000111);
      val_rdy_i = 1'b1; cond_rdy_i = 1'b1; cond_data_i = 64'h1; val_data_i = 64'h8;
      @(negedge clk);
      issue_inst_i = mk_inst(3'b101, 7'b0000001);
      @(negedge clk);
      issue_inst_i = {mk_inst(3'b101, 7'b0000111)} ^ 32'h1;
      @(negedge clk); clear_inputs();
      #1;
      check("R8 not busy after illegal", busy_o, 0);
      watch_quiet(4, vlds);
      check("R8 no result for illegal", XLEN'(vlds), 0);

      // R10: conditional xor sequence, rc non-zero and zero
      for (int j = 0; j < 2; j++) begin
         logic [XLEN-1:0] rs1, rs2, rc;
         rs1 = 64'hF0F0_1234_0000_00FF; rs2 = 64'h0FF0_0000_ABCD_0001; rc = (j == 0) ? 64'h10 : 64'h0;
         run_op(1'b1, 1'b0, rs2, rc, 0, 0, 5'd7, got, r1, rtag, cyc);
         check("R10 conditional xor", rs1 ^ r1, (rc != 0) ? rs1 : (rs1 ^ rs2));
      end
      // R10: conditional select sequence
      for (int j = 0; j < 2; j++) begin
         logic [XLEN-1:0] rs1, rs2, rc;
         rs1 = 64'h1111_2222_3333_4444; rs2 = 64'h9999_8888_7777_6666; rc = (j == 0) ? MSB : 64'h0;
         run_op(1'b1, 1'b1, rs1, rc, 1, 0, 5'd8, got, r1, rtag, cyc);
         run_op(1'b0, 1'b0, rs2, rc, 0, 0, 5'd9, got, r2, rtag, cyc);
         check("R10 conditional select", r1 | r2, (rc != 0) ? rs2 : rs1);
      end

      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule